// File: doc/BRIEF.md
# Register-Stack Arithmetic Execution Unit

This execution unit keeps its operands in a push-down stack of registers rather than in addressable registers. One instruction is taken per accepted request. A load reads a word from a synchronous data memory and pushes it onto the stack. An add removes the two top entries and pushes back their sum. A write removes the top entry and stores it at a memory address. For example, the program "load, load, add, load, add, write" leaves the sum of three memory words in the target word.

Instructions arrive on a valid/ready channel. A request is accepted on a clock edge where `instr_valid` and `instr_ready` are both high. While `instr_ready` is low the requester must hold its request stable. An add or a write completes at its acceptance edge, so `instr_ready` stays high for back-to-back requests of these kinds. A load closes the channel until its read data has been pushed.

The memory port, the flags, the stack depth and the busy, done and error pins are plain signals without handshake. The memory must return read data on the cycle after it sees the read enable.

Top module: `stack_exec_unit`

## Requirements
- R1: Opcode 2'b00 (load) is accepted only when the stack holds fewer than 8 entries. `mem_rd_en` is high for exactly the cycle after acceptance, with `mem_addr` equal to the instruction address. The word returned one cycle later is pushed as the new top. `done` rises three cycles after the acceptance edge, and the depth increases by one.
- R2: Opcode 2'b01 (add) needs at least two entries. It replaces the top two entries with their 16-bit sum and reduces the depth by one. `done` is high in the cycle after acceptance.
- R3: Opcode 2'b10 (write) needs at least one entry. It pops the top entry. In the cycle after acceptance it drives `mem_wr_en`, `mem_addr` and `mem_wdata` with that entry, with `done` high. The depth decreases by one.
- R4: Both programs "load A, load B, add, load C, add, write D" and "load A, load B, load C, add, add, write D" leave (A+B+C) mod 2^16 in D.
- R5: After an add, `flags` = {N,C,Z,V} (bit 3 down to bit 0). N is bit 15 of the sum, C is the unsigned carry out of bit 15, Z means the sum is zero, and V means two's-complement signed overflow.
- R6: Load, write and rejected requests leave `flags` unchanged.
- R7: A load presented when 8 entries are held raises `err` for one cycle. The request gives no `done`, no memory read and no change of depth.
- R8: An add with fewer than two entries, or a write on an empty stack, raises `err` for one cycle. The depth, flags and memory are left unchanged.
- R9: Opcode 2'b11 is reserved. It is rejected with `err` whatever the depth.
- R10: `busy` is high and `instr_ready` is low from a load's acceptance until its pushed value is in the stack. `instr_ready` is high otherwise.
- R11: Reset empties the stack (`depth` = 0), clears `flags`, and drives `busy`, `done`, `err` and both memory enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction request valid |
| instr_ready | output | 1 | Unit can accept an instruction |
| instr_op | input | 2 | 00 load, 01 add, 10 write, 11 reserved |
| instr_addr | input | 8 | Memory address for load and write |
| mem_rd_en | output | 1 | Memory read enable |
| mem_wr_en | output | 1 | Memory write enable |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after `mem_rd_en` |
| busy | output | 1 | Load in flight |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| flags | output | 4 | {N,C,Z,V} from the last add |
| depth | output | 4 | Number of stack entries held |

## Verification
The hardest conditions to reach from the ports are the stack boundaries. Overflow needs eight completed loads in a row before a ninth load can be rejected. Underflow needs the stack drained to one entry, and then to zero, before the add and the write are tried.

The bench drives these chains deliberately. It then sweeps every ordered pair of eight corner words through load, load, add, write. This reaches each combination of carry and signed overflow, together with the zero and negative results.

// File: rtl/sxu_pkg.sv
`timescale 1ns/1ps
package sxu_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_ADD   = 2'b01,
    OP_WRITE = 2'b10,
    OP_RSVD  = 2'b11
  } sxu_op_e;

  typedef enum logic [1:0] {
    SOP_HOLD,
    SOP_PUSH,
    SOP_POP,
    SOP_FOLD
  } stk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_CAPT
  } sxu_state_e;

  typedef struct packed {
    logic n;
    logic c;
    logic z;
    logic v;
  } sxu_flags_t;
endpackage

// File: rtl/sxu_stack_file.sv
`timescale 1ns/1ps
module sxu_stack_file
  import sxu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_op_e           op,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] top0,
  output logic [DATA_W-1:0] top1,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] ent [DEPTH];
  logic [DATA_W-1:0] ext [DEPTH+1];

  assign ext[DEPTH] = '0;

  // entry 0 is the top; a push shifts toward the bottom, a pop toward the top
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] from_above;
    logic [DATA_W-1:0] nxt;

    if (i == 0) begin : g_head
      assign from_above = din;
    end else begin : g_body
      assign from_above = ent[i-1];
    end

    always_comb begin
      nxt = q;
      unique case (op)
        SOP_PUSH: nxt = from_above;
        SOP_POP:  nxt = ext[i+1];
        SOP_FOLD: nxt = (i == 0) ? din : ext[i+1];
        default:  nxt = q;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
    end

    assign ent[i] = q;
    assign ext[i] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      unique case (op)
        SOP_PUSH:         count <= count + 1'b1;
        SOP_POP, SOP_FOLD: count <= count - 1'b1;
        default:          count <= count;
      endcase
    end
  end

  assign top0 = ent[0];
  assign top1 = ent[1];
endmodule

// File: rtl/sxu_adder.sv
`timescale 1ns/1ps
module sxu_adder
  import sxu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum,
  output sxu_flags_t        flg
);
  logic [DATA_W:0] wide;

  assign wide  = {1'b0, a} + {1'b0, b};
  assign sum   = wide[DATA_W-1:0];
  assign flg.n = sum[DATA_W-1];
  assign flg.c = wide[DATA_W];
  assign flg.z = (sum == '0);
  assign flg.v = (a[DATA_W-1] == b[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
endmodule

// File: rtl/stack_exec_unit.sv
`timescale 1ns/1ps
module stack_exec_unit
  import sxu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [1:0]        instr_op,
  input  logic [ADDR_W-1:0] instr_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [3:0]        flags,
  output logic [CNT_W-1:0]  depth
);
  sxu_state_e        state;
  sxu_op_e           op;
  stk_op_e           sop;
  logic [DATA_W-1:0] top0, top1, sum, din;
  sxu_flags_t        add_flg, flg_q;
  logic              accept, full, has1, has2, reject;
  logic              do_load, do_add, do_write;

  assign op     = sxu_op_e'(instr_op);
  assign accept = instr_valid && instr_ready;
  assign full   = (depth == CNT_W'(DEPTH));
  assign has1   = (depth != '0);
  assign has2   = (depth > CNT_W'(1));

  always_comb begin
    unique case (op)
      OP_LOAD:  reject = full;
      OP_ADD:   reject = !has2;
      OP_WRITE: reject = !has1;
      default:  reject = 1'b1;
    endcase
  end

  assign do_load  = accept && !reject && (op == OP_LOAD);
  assign do_add   = accept && !reject && (op == OP_ADD);
  assign do_write = accept && !reject && (op == OP_WRITE);

  always_comb begin
    sop = SOP_HOLD;
    din = sum;
    if (state == ST_CAPT) begin
      sop = SOP_PUSH;
      din = mem_rdata;
    end else if (do_add) begin
      sop = SOP_FOLD;
    end else if (do_write) begin
      sop = SOP_POP;
    end
  end

  sxu_stack_file #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (sop),
    .din   (din),
    .top0  (top0),
    .top1  (top1),
    .count (depth)
  );

  sxu_adder #(.DATA_W(DATA_W)) u_add (
    .a   (top1),
    .b   (top0),
    .sum (sum),
    .flg (add_flg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      flg_q     <= '0;
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      mem_rd_en <= do_load;
      mem_wr_en <= do_write;
      done      <= do_add || do_write || (state == ST_CAPT);
      err       <= accept && reject;
      if (do_load || do_write) mem_addr <= instr_addr;
      if (do_write) mem_wdata <= top0;
      if (do_add)   flg_q     <= add_flg;
      unique case (state)
        ST_IDLE: if (do_load) state <= ST_READ;
        ST_READ: state <= ST_CAPT;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign instr_ready = (state == ST_IDLE);
  assign busy        = (state != ST_IDLE);
  assign flags       = flg_q;
endmodule

// File: rtl/sxu_checker.sv
`timescale 1ns/1ps
module sxu_checker #(
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_ready,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             mem_rd_en,
  input logic             mem_wr_en,
  input logic [3:0]       flags,
  input logic [CNT_W-1:0] depth
);
  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(DEPTH)); // R7
  AST_REJECT_HOLDS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(depth) && !done)); // R8
  AST_FLAGS_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flags) |-> done); // R6
  AST_BUSY_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !instr_ready); // R10
  AST_READ_THEN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (busy && !mem_rd_en)); // R1
  AST_WRITE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (done && !busy && !mem_rd_en)); // R3
endmodule

bind stack_exec_unit sxu_checker #(.DEPTH(DEPTH)) u_sxu_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_ready (instr_ready),
  .busy        (busy),
  .done        (done),
  .err         (err),
  .mem_rd_en   (mem_rd_en),
  .mem_wr_en   (mem_wr_en),
  .flags       (flags),
  .depth       (depth)
);

// File: tb/stack_exec_unit_test.sv
`timescale 1ns/1ps
module stack_exec_unit_test;
  localparam int W = 16;
  localparam int AW = 8;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [1:0] instr_op = 2'b00;
  logic [AW-1:0] instr_addr = '0;
  logic instr_ready, mem_rd_en, mem_wr_en, busy, done, err;
  logic [AW-1:0] mem_addr;
  logic [W-1:0] mem_wdata;
  logic [W-1:0] mem_rdata = '0;
  logic [3:0] flags;
  logic [3:0] depth;

  always #10 clk = ~clk;

  stack_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_op(instr_op), .instr_addr(instr_addr), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .err(err),
    .flags(flags), .depth(depth)
  );

  logic [W-1:0] mem [256];
  logic poke_en = 1'b0;
  logic [AW-1:0] poke_addr = '0;
  logic [W-1:0] poke_data = '0;

  always @(posedge clk) begin
    if (poke_en) mem[poke_addr] <= poke_data;
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  int nvec = 0;
  int nbad = 0;
  int mdepth = 0;
  logic [W-1:0] mstk [D];
  logic [3:0] mflags = 4'h0;
  logic [W-1:0] vals [8];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_flags(input logic [W-1:0] a, input logic [W-1:0] b);
    int us, ss;
    logic [W-1:0] r;
    us = int'(a) + int'(b);
    ss = int'($signed(a)) + int'($signed(b));
    r = us[W-1:0];
    return {r[W-1], us > 65535, r == 0, (ss > 32767) || (ss < -32768)};
  endfunction

  task automatic poke(input logic [AW-1:0] a, input logic [W-1:0] v);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = a; poke_data = v;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                       output int lat, output bit d, output bit e, output bit b1);
    @(negedge clk);
    instr_valid = 1'b1; instr_op = op; instr_addr = a;
    while (!instr_ready) @(negedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
    b1 = busy && !instr_ready;
    lat = 1; d = 0; e = 0;
    repeat (6) begin
      if (done || err) begin
        d = done; e = err;
        break;
      end
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic do_load(input logic [AW-1:0] a);
    int lat; bit d, e, b1;
    logic [3:0] f0;
    f0 = flags;
    issue(2'b00, a, lat, d, e, b1);
    if (mdepth < D) begin
      chk("R1", "load done", d, 1);
      chk("R1", "load latency", lat, 3);
      chk("R10", "busy while load in flight", b1, 1);
      for (int i = D - 1; i > 0; i--) mstk[i] = mstk[i-1];
      mstk[0] = mem[a];
      mdepth++;
      chk("R1", "depth after load", depth, mdepth);
    end else begin
      chk("R7", "err on full push", e, 1);
      chk("R7", "no done on full push", d, 0);
      chk("R7", "depth held", depth, mdepth);
    end
    chk("R6", "flags after load", flags, f0);
  endtask

  task automatic do_add(output logic [W-1:0] s);
    int lat; bit d, e, b1;
    logic [3:0] f0;
    f0 = flags;
    s = '0;
    issue(2'b01, 8'h00, lat, d, e, b1);
    if (mdepth >= 2) begin
      s = mstk[0] + mstk[1];
      mflags = exp_flags(mstk[1], mstk[0]);
      chk("R2", "add done", d, 1);
      chk("R2", "add latency", lat, 1);
      mstk[0] = s;
      for (int i = 1; i < D - 1; i++) mstk[i] = mstk[i+1];
      mdepth--;
      chk("R2", "depth after add", depth, mdepth);
      chk("R5", "flags NCZV", flags, mflags);
    end else begin
      chk("R8", "err on short add", e, 1);
      chk("R8", "depth held", depth, mdepth);
      chk("R8", "flags held", flags, f0);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a);
    int lat; bit d, e, b1;
    logic [3:0] f0;
    logic [W-1:0] m0;
    f0 = flags;
    m0 = mem[a];
    issue(2'b10, a, lat, d, e, b1);
    @(negedge clk);
    if (mdepth >= 1) begin
      chk("R3", "write done", d, 1);
      chk("R3", "write latency", lat, 1);
      chk("R3", "stored word", mem[a], mstk[0]);
      for (int i = 0; i < D - 1; i++) mstk[i] = mstk[i+1];
      mdepth--;
      chk("R3", "depth after write", depth, mdepth);
    end else begin
      chk("R8", "err on empty write", e, 1);
      chk("R8", "memory untouched", mem[a], m0);
      chk("R8", "depth held", depth, mdepth);
    end
    chk("R6", "flags after write", flags, f0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [W-1:0] s;
    int lat; bit d, e, b1;
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
    vals[4] = 16'hFFFF; vals[5] = 16'hFACE; vals[6] = 16'hBADE; vals[7] = 16'h4000;
    for (int i = 0; i < D; i++) mstk[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "depth after reset", depth, 0);
    chk("R11", "flags after reset", flags, 0);
    chk("R11", "busy after reset", busy, 0);
    chk("R11", "done/err after reset", {done, err, mem_rd_en, mem_wr_en}, 0);
    for (int k = 0; k < 8; k++) poke(AW'(k), vals[k]);

    do_add(s);
    do_write(8'd50);
    issue(2'b11, 8'h00, lat, d, e, b1);
    chk("R9", "reserved op rejected empty", e, 1);

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        do_load(AW'(i));
        do_load(AW'(j));
        do_add(s);
        do_write(AW'(64 + i * 8 + j));
      end
    end

    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] a, b, c, x;
      a = vals[k]; b = vals[(k + 3) % 8]; c = vals[(k + 5) % 8];
      x = a + b + c;
      do_load(AW'(k)); do_load(AW'((k + 3) % 8)); do_add(s);
      do_load(AW'((k + 5) % 8)); do_add(s); do_write(8'd200);
      chk("R4", "sequence one result", mem[200], x);
      do_load(AW'(k)); do_load(AW'((k + 3) % 8)); do_load(AW'((k + 5) % 8));
      do_add(s); do_add(s); do_write(8'd201);
      chk("R4", "sequence two result", mem[201], x);
    end

    for (int k = 0; k < 8; k++) do_load(AW'(k));
    do_load(8'd0);
    issue(2'b11, 8'h00, lat, d, e, b1);
    chk("R9", "reserved op rejected full", e, 1);
    chk("R9", "depth held", depth, mdepth);
    for (int k = 0; k < 7; k++) do_add(s);
    do_add(s);
    do_write(8'd210);
    do_write(8'd211);
    do_add(s);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule